// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block produces the frame synchronisation signals for a two-phase serial audio port. A counter advances once per bit clock and marks the start of each frame, holding the sync active for a programmable number of bits. The bit clock comes from one of two sources. The first is a one-cycle enable from an internal clock divider. The second is an external bit-clock pin, which the block resynchronises and edge-detects. Period and active width are both given as "count minus one" values, so a stereo frame of two 16-bit words uses a period value of 31. A width value of 15 then yields a sync pulse as long as one channel.

The transmit and receive syncs are handled by two identical port slices. Each slice has its own direction and polarity control. When a slice drives, the internal generator sets the pin level. When it listens, the slice takes the pin from outside, resynchronises it and only corrects its polarity. Every slice gives an active-high view of its sync and a one-cycle strobe at the first bit of each frame. The generator can run free or emit one frame per request. It has a run control that is separate from its sync enable.

Top module: `frame_sync_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `fs_active` and `frame_stb` are 0, and each `fs_pin_o` bit equals its `fs_pol` bit, which is the inactive level.
- R2: In periodic mode, a driving port marks each frame with `frame_stb` high in the cycle after a bit tick. This happens every `period_m1`+1 ticks, starting with the first tick after enabling.
- R3: In a frame, a driving port holds `fs_active` high for bit indices 0 through `width_m1`. If `width_m1` ≥ `period_m1`, the sync stays high for the whole frame.
- R4: Frames appear only while both `gen_run` and `fs_en` are 1. Clearing either one forces the sync inactive at the next bit tick. The first tick after both are set again starts a new frame at bit 0.
- R5: With `periodic` = 0, no frame starts without a request. Each one-cycle `shot_req` pulse produces exactly one frame, after which the sync stays inactive.
- R6: The pin level is `fs_active` XOR `fs_pol`: pol 0 gives an active-high pin and pol 1 gives an active-low pin. Each port uses its own pol bit.
- R7: With `fs_dir_out`[i] = 1, port i drives its pin (`fs_pin_oe` = 1) from the generator. With `fs_dir_out`[i] = 0, `fs_pin_oe` is 0 and `fs_active` equals the resynchronised pin XOR pol, whatever the generator does. Index 0 is transmit and index 1 is receive.
- R8: A listening port sets `fs_active` and a one-cycle `frame_stb` on the third clock edge after its pin moves to the active level.
- R9: With `clk_src_ext` = 0, each `int_bit_tick` cycle is one bit tick. With `clk_src_ext` = 1, each rising edge of `ext_bclk` is one bit tick and `int_bit_tick` has no effect.
- R10: In drive mode, `frame_stb` is high for one clock cycle only per frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_src_ext | input | 1 | 1: bit clock from ext_bclk; 0: from int_bit_tick |
| int_bit_tick | input | 1 | Bit-clock enable from the internal divider |
| ext_bclk | input | 1 | External bit-clock pin (asynchronous) |
| period_m1 | input | CNT_W | Bit ticks per frame minus one |
| width_m1 | input | CNT_W | Active sync length in bits minus one |
| periodic | input | 1 | 1: free-running frames; 0: one frame per request |
| shot_req | input | 1 | One-shot frame request |
| gen_run | input | 1 | Generator out of reset |
| fs_en | input | 1 | Frame sync output enable |
| fs_dir_out | input | 2 | Per port: 1 drive, 0 listen |
| fs_pol | input | 2 | Per port: 0 active high, 1 active low |
| fs_pin_i | input | 2 | Sync pin levels from outside |
| fs_pin_o | output | 2 | Sync pin drive levels |
| fs_pin_oe | output | 2 | Sync pin output enables |
| fs_active | output | 2 | Active-high sync view per port |
| frame_stb | output | 2 | One-cycle frame start strobe per port |

## Verification
The bench sweeps all period and width values up to eight bits, including widths at and past the period. A counter that wraps one bit early or late, or a width comparator that is off by one, shows up there as a shifted strobe or a pulse of the wrong length. Enable and run are dropped in the middle of a frame. A design that lets the count run on, or resumes where it stopped instead of at bit 0, would show a missing or late strobe. In one-shot mode the bench checks that no frame starts without a request and that a request yields exactly one frame. A design that keeps the request latched would repeat frames. Internal ticks are pulsed while the external clock is selected, and a design that merged the two sources would advance the count. Listening ports must ignore a running generator and follow their pin with the stated latency and polarity.

// File: rtl/fsg_pkg.sv
// Package: shared constants for the frame sync generator.
// Assumes two sync ports, indexed transmit then receive.
package fsg_pkg;
    localparam int NUM_PORTS = 2;
    localparam int PORT_TX   = 0;
    localparam int PORT_RX   = 1;
endpackage

// File: rtl/fsg_tick_sel.sv
// Module: fsg_tick_sel
// Picks the bit-clock enable: either the internal divider pulse or the
// rising edge of a resynchronised external bit-clock pin.
// Assumes ext_bclk is asynchronous and much slower than clk.
module fsg_tick_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_ext,
    input  logic int_tick,
    input  logic ext_clk,
    output logic bit_tick
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         last_q;
    logic         ext_tick;

    // Resynchronise the external clock and keep its previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[MSB-1:0], ext_clk};
            last_q <= sync_q[MSB];
        end
    end

    // Rising edge of the synchronised external clock.
    assign ext_tick = sync_q[MSB] & ~last_q;

    // Select the source of the bit tick.
    always_comb begin
        bit_tick = use_ext ? ext_tick : int_tick;
    end
endmodule

// File: rtl/fsg_counter.sv
// Module: fsg_counter
// Frame counter: walks bit indices 0..period_m1 on each bit tick. It raises
// the active sync for indices 0..width_m1 and a strobe at index 0.
// Assumes control inputs are quasi-static; a lowered period ends the frame.
module fsg_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             gen_run,
    input  logic             fs_en,
    input  logic             periodic,
    input  logic             shot_req,
    input  logic [CNT_W-1:0] period_m1,
    input  logic [CNT_W-1:0] width_m1,
    output logic             gen_act,
    output logic             gen_stb
);
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] nxt_idx;
    logic             busy_q;
    logic             pend_q;
    logic             run;
    logic             at_end;
    logic             go;
    logic             consume;

    // Decode run state, frame end and whether a new frame may start.
    always_comb begin
        run     = gen_run & fs_en;
        at_end  = busy_q & (idx_q >= period_m1);
        go      = periodic | pend_q;
        nxt_idx = idx_q + 1'b1;
        consume = bit_tick & run & (~busy_q | at_end) & go;
    end

    // Hold a one-shot request until a frame consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pend_q <= 1'b0;
        end else if (shot_req && !periodic) begin
            pend_q <= 1'b1;
        end else if (consume) begin
            pend_q <= 1'b0;
        end
    end

    // Advance the bit index and drive the sync and strobe per bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            busy_q  <= 1'b0;
            gen_act <= 1'b0;
            gen_stb <= 1'b0;
        end else begin
            gen_stb <= 1'b0;
            if (bit_tick) begin
                if (!run) begin
                    idx_q   <= '0;
                    busy_q  <= 1'b0;
                    gen_act <= 1'b0;
                end else if (!busy_q || at_end) begin
                    idx_q   <= '0;
                    busy_q  <= go;
                    gen_act <= go;
                    gen_stb <= go;
                end else begin
                    idx_q   <= nxt_idx;
                    gen_act <= (nxt_idx <= width_m1);
                end
            end
        end
    end
endmodule

// File: rtl/fsg_pin_port.sv
// Module: fsg_pin_port
// One sync pin slice: either drives the generator's sync with polarity applied,
// or takes the pin from outside, resynchronises it and corrects polarity.
// Assumes the external pin is asynchronous to clk.
module fsg_pin_port #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_out,
    input  logic pol,
    input  logic pin_i,
    input  logic gen_act,
    input  logic gen_stb,
    output logic pin_o,
    output logic pin_oe,
    output logic fs_act,
    output logic frm_stb
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         in_lvl;
    logic         in_act_q;
    logic         in_stb_q;

    // Resynchronise the incoming pin; reset to its inactive level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{pol}};
        end else begin
            sync_q <= {sync_q[MSB-1:0], pin_i};
        end
    end

    // Active-high level of the incoming pin.
    assign in_lvl = sync_q[MSB] ^ pol;

    // Register the incoming sync and flag its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_act_q <= 1'b0;
            in_stb_q <= 1'b0;
        end else begin
            in_act_q <= in_lvl;
            in_stb_q <= in_lvl & ~in_act_q;
        end
    end

    // Choose the sync source and form the pin drive.
    always_comb begin
        pin_oe  = dir_out;
        pin_o   = gen_act ^ pol;
        fs_act  = dir_out ? gen_act : in_act_q;
        frm_stb = dir_out ? gen_stb : in_stb_q;
    end
endmodule

// File: rtl/frame_sync_gen.sv
// Module: frame_sync_gen (top)
// Frame sync generator for a two-phase serial audio port: clock source
// select, frame counter and one pin slice per sync (transmit, receive).
// Assumes all controls come from direct ports and change between frames.
module frame_sync_gen
    import fsg_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_src_ext,
    input  logic                 int_bit_tick,
    input  logic                 ext_bclk,
    input  logic [CNT_W-1:0]     period_m1,
    input  logic [CNT_W-1:0]     width_m1,
    input  logic                 periodic,
    input  logic                 shot_req,
    input  logic                 gen_run,
    input  logic                 fs_en,
    input  logic [NUM_PORTS-1:0] fs_dir_out,
    input  logic [NUM_PORTS-1:0] fs_pol,
    input  logic [NUM_PORTS-1:0] fs_pin_i,
    output logic [NUM_PORTS-1:0] fs_pin_o,
    output logic [NUM_PORTS-1:0] fs_pin_oe,
    output logic [NUM_PORTS-1:0] fs_active,
    output logic [NUM_PORTS-1:0] frame_stb
);
    logic bit_tick;
    logic gen_act;
    logic gen_stb;

    fsg_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_ext  (clk_src_ext),
        .int_tick (int_bit_tick),
        .ext_clk  (ext_bclk),
        .bit_tick (bit_tick)
    );

    fsg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .gen_run   (gen_run),
        .fs_en     (fs_en),
        .periodic  (periodic),
        .shot_req  (shot_req),
        .period_m1 (period_m1),
        .width_m1  (width_m1),
        .gen_act   (gen_act),
        .gen_stb   (gen_stb)
    );

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_port
        fsg_pin_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir_out (fs_dir_out[gi]),
            .pol     (fs_pol[gi]),
            .pin_i   (fs_pin_i[gi]),
            .gen_act (gen_act),
            .gen_stb (gen_stb),
            .pin_o   (fs_pin_o[gi]),
            .pin_oe  (fs_pin_oe[gi]),
            .fs_act  (fs_active[gi]),
            .frm_stb (frame_stb[gi])
        );
    end
endmodule

// File: rtl/frame_sync_gen_chk.sv
// Module: frame_sync_gen_chk
// Property checker bound to frame_sync_gen; observes the ports and the
// signals passed between the tick selector, counter and pin slices.
module frame_sync_gen_chk
    import fsg_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bit_tick,
    input logic                 gen_run,
    input logic                 fs_en,
    input logic                 gen_act,
    input logic                 gen_stb,
    input logic [NUM_PORTS-1:0] fs_dir_out,
    input logic [NUM_PORTS-1:0] fs_pol,
    input logic [NUM_PORTS-1:0] fs_pin_o,
    input logic [NUM_PORTS-1:0] fs_active,
    input logic [NUM_PORTS-1:0] frame_stb
);
    // R4: a tick while stopped leaves the generator inactive.
    a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !(gen_run && fs_en)) |=> (!gen_act && !gen_stb));

    // R9: the counter output only moves on a bit tick.
    a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> ($stable(gen_act) && !gen_stb));

    // R2: a frame start always coincides with bit 0 being active.
    a_r2_stb_with_act: assert property (@(posedge clk) disable iff (!rst_n)
        gen_stb |-> gen_act);

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_chk
        // R6: a driven pin carries the sync with its polarity applied.
        a_r6_pin_polarity: assert property (@(posedge clk) disable iff (!rst_n)
            fs_dir_out[gi] |-> (fs_pin_o[gi] == (fs_active[gi] ^ fs_pol[gi])));

        // R10: a port strobe marks an active sync.
        a_r10_stb_active: assert property (@(posedge clk) disable iff (!rst_n)
            frame_stb[gi] |-> fs_active[gi]);

        // R8: in listen mode a strobe follows an inactive cycle.
        a_r8_listen_edge: assert property (@(posedge clk) disable iff (!rst_n)
            (!fs_dir_out[gi] && $past(!fs_dir_out[gi]) && frame_stb[gi])
                |-> $past(!fs_active[gi]));
    end
endmodule

bind frame_sync_gen frame_sync_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .gen_run    (gen_run),
    .fs_en      (fs_en),
    .gen_act    (gen_act),
    .gen_stb    (gen_stb),
    .fs_dir_out (fs_dir_out),
    .fs_pol     (fs_pol),
    .fs_pin_o   (fs_pin_o),
    .fs_active  (fs_active),
    .frame_stb  (frame_stb)
);

// File: tb/frame_sync_gen_bench.sv
`timescale 1ns/1ps
// Bench for frame_sync_gen: sweeps small periods and widths, then checks
// gating, one-shot frames, clock source select and listen mode.
module frame_sync_gen_bench;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clk_src_ext;
    logic          int_bit_tick;
    logic          ext_bclk;
    logic [CW-1:0] period_m1;
    logic [CW-1:0] width_m1;
    logic          periodic;
    logic          shot_req;
    logic          gen_run;
    logic          fs_en;
    logic [1:0]    fs_dir_out;
    logic [1:0]    fs_pol;
    logic [1:0]    fs_pin_i;
    logic [1:0]    fs_pin_o;
    logic [1:0]    fs_pin_oe;
    logic [1:0]    fs_active;
    logic [1:0]    frame_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // 125 MHz clock.
    always #4 clk = ~clk;

    frame_sync_gen #(.CNT_W(CW)) u_frame_sync_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_src_ext  (clk_src_ext),
        .int_bit_tick (int_bit_tick),
        .ext_bclk     (ext_bclk),
        .period_m1    (period_m1),
        .width_m1     (width_m1),
        .periodic     (periodic),
        .shot_req     (shot_req),
        .gen_run      (gen_run),
        .fs_en        (fs_en),
        .fs_dir_out   (fs_dir_out),
        .fs_pol       (fs_pol),
        .fs_pin_i     (fs_pin_i),
        .fs_pin_o     (fs_pin_o),
        .fs_pin_oe    (fs_pin_oe),
        .fs_active    (fs_active),
        .frame_stb    (frame_stb)
    );

    // Compare one value and report a mismatch.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One internal bit tick; returns at the negedge after it is taken.
    task automatic tick_int();
        @(negedge clk) int_bit_tick = 1'b1;
        @(negedge clk) int_bit_tick = 1'b0;
    endtask

    // One external bit-clock period; returns once everything has settled.
    task automatic tick_ext();
        @(negedge clk) ext_bclk = 1'b1;
        repeat (4) @(negedge clk);
        ext_bclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Main stimulus and checks.
    initial begin
        rst_n = 1'b0; clk_src_ext = 1'b0; int_bit_tick = 1'b0; ext_bclk = 1'b0;
        period_m1 = '0; width_m1 = '0; periodic = 1'b1; shot_req = 1'b0;
        gen_run = 1'b0; fs_en = 1'b0; fs_dir_out = 2'b11; fs_pol = 2'b10;
        fs_pin_i = 2'b10;
        repeat (3) @(negedge clk);
        check("R1 active in reset", fs_active, 2'b00);
        check("R1 strobe in reset", frame_stb, 2'b00);
        check("R1 pin idle level", fs_pin_o, 2'b10);
        check("R7 oe follows dir", fs_pin_oe, 2'b11);
        rst_n = 1'b1;

        // R4: enable alone, without run, gives no frames.
        period_m1 = 8'd3; width_m1 = 8'd1; fs_en = 1'b1;
        for (int k = 0; k < 5; k++) begin
            tick_int();
            check("R4 no frame without run", {frame_stb, fs_active}, 4'b0000);
        end

        // R2/R3/R6/R10: sweep periods 1..8 and widths 1..period+1.
        gen_run = 1'b1;
        for (int p = 1; p <= 8; p++) begin
            for (int w = 1; w <= p + 1; w++) begin
                fs_en = 1'b0;
                tick_int();
                check("R4 disable clears", fs_active, 2'b00);
                period_m1 = CW'(p - 1);
                width_m1  = CW'(w - 1);
                fs_pol    = (p % 2 == 1) ? 2'b01 : 2'b10;
                fs_en     = 1'b1;
                for (int n = 0; n < 3 * p; n++) begin
                    logic ea;
                    logic es;
                    tick_int();
                    ea = ((n % p) < w);
                    es = ((n % p) == 0);
                    check("R3 width", fs_active, {ea, ea});
                    check("R6 pin polarity", fs_pin_o, {ea, ea} ^ fs_pol);
                    check("R2 frame strobe", frame_stb, {es, es});
                    if (es) begin
                        @(negedge clk);
                        check("R10 strobe one cycle", frame_stb, 2'b00);
                    end
                end
            end
        end

        // R4: stop and restart in the middle of a frame.
        fs_pol = 2'b00; fs_en = 1'b0; tick_int();
        period_m1 = 8'd3; width_m1 = 8'd1; fs_en = 1'b1;
        tick_int(); check("R4 first bit", {frame_stb, fs_active}, 4'b1111);
        tick_int(); check("R4 second bit", {frame_stb, fs_active}, 4'b0011);
        fs_en = 1'b0;
        tick_int(); check("R4 enable drop", {frame_stb, fs_active}, 4'b0000);
        tick_int(); check("R4 stays idle", {frame_stb, fs_active}, 4'b0000);
        fs_en = 1'b1;
        tick_int(); check("R4 restart at bit 0", {frame_stb, fs_active}, 4'b1111);
        tick_int(); check("R4 restart bit 1", {frame_stb, fs_active}, 4'b0011);
        gen_run = 1'b0;
        tick_int(); check("R4 run drop", {frame_stb, fs_active}, 4'b0000);
        gen_run = 1'b1;
        tick_int(); check("R4 run restart", {frame_stb, fs_active}, 4'b1111);

        // R5: one-shot frames.
        periodic = 1'b0; fs_en = 1'b0; tick_int();
        period_m1 = 8'd2; width_m1 = 8'd0; fs_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick_int();
            check("R5 no request no frame", {frame_stb, fs_active}, 4'b0000);
        end
        for (int r = 0; r < 2; r++) begin
            @(negedge clk) shot_req = 1'b1;
            @(negedge clk) shot_req = 1'b0;
            for (int n = 0; n < 6; n++) begin
                logic e0;
                tick_int();
                e0 = (n == 0);
                check("R5 single frame", {frame_stb, fs_active}, {e0, e0, e0, e0});
            end
        end

        // R9: external bit clock; internal ticks ignored.
        periodic = 1'b1; clk_src_ext = 1'b1; fs_en = 1'b0;
        period_m1 = 8'd1; width_m1 = 8'd0;
        tick_ext();
        fs_en = 1'b1;
        tick_ext(); check("R9 ext tick bit 0", fs_active, 2'b11);
        tick_int(); check("R9 int tick ignored", fs_active, 2'b11);
        tick_ext(); check("R9 ext tick bit 1", fs_active, 2'b00);
        tick_int(); check("R9 int tick ignored again", fs_active, 2'b00);
        tick_ext(); check("R9 ext next frame", fs_active, 2'b11);
        clk_src_ext = 1'b0;

        // R7/R8: both ports listen; tx active low, rx active high.
        period_m1 = 8'd3; width_m1 = 8'd1;
        fs_dir_out = 2'b00; fs_pol = 2'b01; fs_pin_i = 2'b01;
        repeat (4) @(negedge clk);
        check("R7 oe off in listen", fs_pin_oe, 2'b00);
        check("R7 idle pins", fs_active, 2'b00);
        for (int k = 0; k < 3; k++) begin
            tick_int();
            check("R7 generator ignored", {frame_stb, fs_active}, 4'b0000);
        end
        @(negedge clk) fs_pin_i = 2'b00;
        @(negedge clk); @(negedge clk);
        check("R8 not yet after two edges", fs_active, 2'b00);
        @(negedge clk);
        check("R8 tx active low seen", fs_active, 2'b01);
        check("R8 tx strobe", frame_stb, 2'b01);
        @(negedge clk);
        check("R8 tx strobe ends", frame_stb, 2'b00);
        check("R8 tx stays active", fs_active, 2'b01);
        fs_pin_i = 2'b10;
        repeat (3) @(negedge clk);
        check("R8 rx active high seen", fs_active, 2'b11);
        check("R8 rx strobe", frame_stb, 2'b10);
        fs_pin_i = 2'b01;
        repeat (3) @(negedge clk);
        check("R7 both released", {frame_stb, fs_active}, 4'b0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule